// File: doc/BRIEF.md
# Two-wire EEPROM target engine

This block is the protocol core of a byte-addressed serial EEPROM that sits on a two-wire bus as a target. A front end outside the block filters the bus. It hands the engine single-cycle events: a start, a stop, a clock rising edge together with the sampled data bit, and a clock falling edge. The engine answers with one open-drain enable, `sda_pull`. When that signal is high the data line is pulled low. When it is low the line is released. The engine decodes the device-select word, collects a two-byte memory address, passes received data bytes to a write port, and streams stored bytes back to the host. The write port also updates a small internal array.

The address pointer is 15 bits wide. Writes step only the six low bits, so a page write stays inside its 64-byte page. Reads step the whole pointer, so the address runs across page boundaries and goes from the top address back to zero. The storage array keeps 2^ARR_AW bytes and is indexed by the low ARR_AW bits of the pointer, so higher addresses alias onto it.

The controller has eight states:
- `ST_IDLE`: the bus is quiet.
- `ST_SEL`: receiving the select word.
- `ST_AHI`: receiving the high address byte.
- `ST_ALO`: receiving the low address byte.
- `ST_WDAT`: receiving data bytes.
- `ST_TX`: shifting a byte out.
- `ST_HACK`: sampling the host acknowledge.
- `ST_HOLD`: released until the next start.

The transitions are:
- A start moves any state to `ST_SEL`, and a stop moves any state to `ST_IDLE`. A start wins when both arrive together.
- In `ST_SEL`, a select word that does not match goes to `ST_HOLD` at the falling edge after bit 8.
- In `ST_SEL`, a matching word goes at the ninth rising edge to `ST_TX` for a read or to `ST_AHI` for a write.
- `ST_AHI` goes to `ST_ALO`, and `ST_ALO` goes to `ST_WDAT`, each at the ninth rising edge.
- `ST_TX` goes to `ST_HACK` at the falling edge after its eighth bit.
- `ST_HACK` goes back to `ST_TX` on a host acknowledge of 0, or to `ST_HOLD` on a 1.

Top module: `eep_i2c_target`

## Requirements
- R1: The select word arrives MSB first as fixed code 1010 (bits 7:4), then three strap bits that must equal `strap[2:0]` (bits 3:1), then a direction bit where 1 means read (bit 0). A matching word is acknowledged: `sda_pull` rises at the falling edge after bit 8 and drops at the falling edge after the ninth rising edge.
- R2: A select word with the wrong fixed code or the wrong strap bits gets no acknowledge. `sda_pull` stays low for every following bit until the next start.
- R3: After a write select, a high and then a low address byte are received and each is acknowledged. Bit 7 of the high byte is ignored, and the pointer becomes {high[6:0], low}.
- R4: Each data byte after the address is acknowledged. At the ninth rising edge `wb_we` pulses for one cycle with `wb_addr` equal to the pointer and `wb_data` equal to the byte. The pointer then steps its six low bits modulo 64 and keeps bits 14:6.
- R5: Read data is sent MSB first. A 0 bit holds `sda_pull` high and a 1 bit leaves it low. Each bit is presented at a falling edge, and the first bit comes at the falling edge after the acknowledge slot. The line is released during the host acknowledge slot.
- R6: A host acknowledge of 0 makes the engine send the byte at the next address. Read stepping covers the whole 15-bit range and goes from 0x7FFF to 0x0000.
- R7: After a host acknowledge of 1, `sda_pull` stays low through any further clocks until a start or a stop.
- R8: A write header carrying two address bytes, followed by a repeated start and a read select, returns the byte at the loaded address first.
- R9: A read with no address phase returns the byte just after the last one accessed. After a write that follows the page stepping of R4, and after a read that follows the stepping of R6.
- R10: A start at any point abandons the transaction, releases the line and restarts select decoding.
- R11: Storage holds 2^ARR_AW bytes (default 256), indexed by the low ARR_AW bits of the pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| strap | input | 3 | Board-strapped select bits |
| ev_start | input | 1 | Start event pulse |
| ev_stop | input | 1 | Stop event pulse |
| ev_rise | input | 1 | Clock rising-edge pulse, `bit_in` valid |
| ev_fall | input | 1 | Clock falling-edge pulse |
| bit_in | input | 1 | Data bit sampled at the rising edge |
| sda_pull | output | 1 | Open-drain enable, 1 pulls the line low |
| wb_we | output | 1 | Write-port strobe |
| wb_addr | output | 15 | Write-port byte address |
| wb_data | output | 8 | Write-port data |

## Verification
The bench sweeps all eight strap codes and one wrong fixed code. A decoder that checked too few bits would acknowledge a foreign device. A decoder that failed to go silent would acknowledge later bytes.

A page write starts two bytes below the page end. This catches a pointer that carries out of the page. A sequential read from the same place must instead cross into the next page, which catches reads that reuse the page rule. A read across 0x7FFF must come back around to zero.

Clocks issued after a not-acknowledge, and a start issued while a 0 bit is being driven, expose an engine that keeps talking on the line.

// File: rtl/eep_pkg.sv
package eep_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_SEL, ST_AHI, ST_ALO, ST_WDAT, ST_TX, ST_HACK, ST_HOLD
    } eep_state_t;

    localparam int           BYTE_W   = 8;
    localparam logic [3:0]   SEL_CODE = 4'b1010;
    localparam logic [3:0]   BIT_LAST = 4'd8;
endpackage

// File: rtl/eep_sel_match.sv
module eep_sel_match #(
    parameter int STRAP_W = 3
) (
    input  logic [7:0]         word,
    input  logic [STRAP_W-1:0] strap,
    output logic               hit,
    output logic               is_read
);
    import eep_pkg::*;

    // Layout: code in [7:4], strap copy in [3:1], direction in [0]
    always_comb begin
        hit     = (word[7:4] == SEL_CODE) && (word[STRAP_W:1] == strap);
        is_read = word[0];
    end
endmodule

// File: rtl/eep_addr_step.sv
module eep_addr_step #(
    parameter int ADDR_W  = 15,
    parameter int PAGE_AW = 6
) (
    input  logic [ADDR_W-1:0] cur,
    output logic [ADDR_W-1:0] rd_next,
    output logic [ADDR_W-1:0] wr_next
);
    logic [PAGE_AW-1:0] in_page;

    always_comb begin
        in_page = cur[PAGE_AW-1:0] + 1'b1;
        rd_next = cur + 1'b1;
        wr_next = {cur[ADDR_W-1:PAGE_AW], in_page};
    end
endmodule

// File: rtl/eep_store.sv
module eep_store #(
    parameter int ARR_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ARR_AW-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ARR_AW-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ARR_AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    // R11: a written byte is held at its aliased slot
    assert_store_keeps_R11: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/eep_i2c_target.sv
module eep_i2c_target #(
    parameter int ADDR_W  = 15,
    parameter int PAGE_AW = 6,
    parameter int ARR_AW  = 8,
    parameter int STRAP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STRAP_W-1:0] strap,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              ev_rise,
    input  logic              ev_fall,
    input  logic              bit_in,
    output logic              sda_pull,
    output logic              wb_we,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [7:0]        wb_data
);
    import eep_pkg::*;

    localparam int HI_W = ADDR_W - BYTE_W;

    eep_state_t        st, st_n;
    logic [3:0]        cnt;
    logic [7:0]        shreg;
    logic [7:0]        tx;
    logic [HI_W-1:0]   hi;
    logic [ADDR_W-1:0] addr;
    logic [ADDR_W-1:0] rd_next, wr_next;
    logic [7:0]        rdata;
    logic              hit, is_read;
    logic              byte_done, ack_rise, ack_fall;

    eep_sel_match #(.STRAP_W(STRAP_W)) u_match (
        .word(shreg), .strap(strap), .hit(hit), .is_read(is_read)
    );

    eep_addr_step #(.ADDR_W(ADDR_W), .PAGE_AW(PAGE_AW)) u_step (
        .cur(addr), .rd_next(rd_next), .wr_next(wr_next)
    );

    eep_store #(.ARR_AW(ARR_AW)) u_store (
        .clk(clk), .rst_n(rst_n), .we(wb_we),
        .waddr(addr[ARR_AW-1:0]), .wdata(shreg),
        .raddr(addr[ARR_AW-1:0]), .rdata(rdata)
    );

    assign byte_done = (cnt == BIT_LAST);
    assign ack_rise  = ev_rise && byte_done && !ev_start && !ev_stop;
    assign ack_fall  = ev_fall && byte_done;

    // Next-state logic
    always_comb begin
        st_n = st;
        if (ev_start) begin
            st_n = ST_SEL;
        end else if (ev_stop) begin
            st_n = ST_IDLE;
        end else begin
            unique case (st)
                ST_SEL: begin
                    if (ack_fall && !hit)  st_n = ST_HOLD;
                    else if (ack_rise)     st_n = is_read ? ST_TX : ST_AHI;
                end
                ST_AHI:  if (ack_rise) st_n = ST_ALO;
                ST_ALO:  if (ack_rise) st_n = ST_WDAT;
                ST_WDAT: st_n = ST_WDAT;
                ST_TX:   if (ack_fall) st_n = ST_HACK;
                ST_HACK: if (ev_rise)  st_n = bit_in ? ST_HOLD : ST_TX;
                ST_HOLD: st_n = ST_HOLD;
                ST_IDLE: st_n = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_n;
    end

    // Datapath: bit counter, shifters, pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            shreg <= '0;
            tx    <= '0;
            hi    <= '0;
            addr  <= '0;
        end else if (ev_start) begin
            cnt <= '0;
        end else if (!ev_stop) begin
            unique case (st)
                ST_SEL, ST_AHI, ST_ALO, ST_WDAT: begin
                    if (ev_rise && !byte_done) begin
                        shreg <= {shreg[6:0], bit_in};
                        cnt   <= cnt + 1'b1;
                    end else if (ev_rise) begin
                        cnt <= '0;
                        if (st == ST_SEL && is_read) begin
                            tx   <= rdata;
                            addr <= rd_next;
                        end
                        if (st == ST_AHI)  hi   <= shreg[HI_W-1:0];
                        if (st == ST_ALO)  addr <= {hi, shreg};
                        if (st == ST_WDAT) addr <= wr_next;
                    end
                end
                ST_TX: begin
                    if (ev_fall && !byte_done) begin
                        tx  <= {tx[6:0], 1'b0};
                        cnt <= cnt + 1'b1;
                    end else if (ev_fall) begin
                        cnt <= '0;
                    end
                end
                ST_HACK: begin
                    if (ev_rise && !bit_in) begin
                        tx   <= rdata;
                        addr <= rd_next;
                        cnt  <= '0;
                    end
                end
                ST_HOLD, ST_IDLE: begin
                    cnt <= '0;
                end
            endcase
        end
    end

    // Output register: open-drain enable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_pull <= 1'b0;
        end else if (ev_start || ev_stop) begin
            sda_pull <= 1'b0;
        end else if (ev_fall) begin
            unique case (st)
                ST_SEL:                  sda_pull <= byte_done && hit;
                ST_AHI, ST_ALO, ST_WDAT: sda_pull <= byte_done;
                ST_TX:                   sda_pull <= !byte_done && !tx[7];
                ST_HACK, ST_HOLD, ST_IDLE: sda_pull <= 1'b0;
            endcase
        end
    end

    assign wb_we   = (st == ST_WDAT) && ack_rise;
    assign wb_addr = addr;
    assign wb_data = shreg;

    // R2 / R7: silent states never pull the line
    assert_hold_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD || st == ST_IDLE) |-> !sda_pull);

    // R5: the line only changes at a falling edge or a bus condition
    assert_pull_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull != $past(sda_pull)) |-> $past(ev_fall || ev_start || ev_stop));

    // R10: start restarts select decoding with the line released
    assert_start_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start |=> (st == ST_SEL && cnt == 4'd0 && !sda_pull));

    // R4: a page write keeps the page bits of the pointer
    assert_page_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wb_we |=> addr[ADDR_W-1:PAGE_AW] == $past(addr[ADDR_W-1:PAGE_AW]));

    // R6: a host acknowledge of 0 advances the pointer by one
    assert_read_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HACK && ev_rise && !bit_in && !ev_start && !ev_stop)
        |=> addr == $past(addr) + 1'b1);
endmodule

// File: tb/tb_eep_i2c_target.sv
module tb_eep_i2c_target;
    localparam int CLK_P = 10;
    localparam logic [2:0] MY_STRAP = 3'b101;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  strap = MY_STRAP;
    logic        ev_start = 1'b0, ev_stop = 1'b0, ev_rise = 1'b0, ev_fall = 1'b0;
    logic        bit_in = 1'b0;
    logic        sda_pull, wb_we;
    logic [14:0] wb_addr;
    logic [7:0]  wb_data;

    int checks = 0;
    int fails  = 0;
    logic [7:0]  model [256];
    logic [14:0] cap_addr;
    logic [7:0]  cap_data;
    int          cap_n = 0;

    always #(CLK_P/2) clk = ~clk;

    eep_i2c_target dut (
        .clk(clk), .rst_n(rst_n), .strap(strap),
        .ev_start(ev_start), .ev_stop(ev_stop), .ev_rise(ev_rise), .ev_fall(ev_fall),
        .bit_in(bit_in), .sda_pull(sda_pull),
        .wb_we(wb_we), .wb_addr(wb_addr), .wb_data(wb_data)
    );

    always @(posedge clk) if (wb_we) begin
        cap_addr <= wb_addr;
        cap_data <= wb_data;
        cap_n    <= cap_n + 1;
    end

    task automatic chk(input logic ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
        end
    endtask

    task automatic pulse(input logic s, input logic p, input logic r, input logic f, input logic b);
        @(negedge clk);
        ev_start = s; ev_stop = p; ev_rise = r; ev_fall = f; bit_in = b;
        @(negedge clk);
        ev_start = 0; ev_stop = 0; ev_rise = 0; ev_fall = 0; bit_in = 0;
    endtask

    task automatic do_start(); pulse(1, 0, 0, 0, 0); endtask
    task automatic do_stop();  pulse(0, 1, 0, 0, 0); endtask

    // one clock: rising edge with wired-AND line value, then falling edge
    task automatic host_bit(input logic b);
        logic line;
        line = b & ~sda_pull;
        pulse(0, 0, 1, 0, line);
        pulse(0, 0, 0, 1, 0);
    endtask

    task automatic put_byte(input logic [7:0] v, output logic acked);
        for (int i = 7; i >= 0; i--) host_bit(v[i]);
        acked = sda_pull;
        host_bit(1'b1);
    endtask

    task automatic get_byte(input logic host_ack, output logic [7:0] v, output logic rel);
        for (int i = 7; i >= 0; i--) begin
            v[i] = ~sda_pull;
            host_bit(1'b1);
        end
        rel = ~sda_pull;
        host_bit(host_ack);
    endtask

    function automatic logic [7:0] sel(input logic [2:0] s, input logic rd);
        return {4'b1010, s, rd};
    endfunction

    // write header: select, high byte, low byte; checks the three acks (R3)
    task automatic wr_header(input logic [7:0] hi, input logic [7:0] lo);
        logic a;
        do_start();
        put_byte(sel(MY_STRAP, 1'b0), a); chk(a, "R1 write select ack", a, 1);
        put_byte(hi, a);                  chk(a, "R3 high address ack", a, 1);
        put_byte(lo, a);                  chk(a, "R3 low address ack", a, 1);
    endtask

    task automatic byte_write(input logic [14:0] ad, input logic [7:0] d);
        logic a;
        wr_header({1'b0, ad[14:8]}, ad[7:0]);
        put_byte(d, a);
        chk(a, "R4 data ack", a, 1);
        model[ad[7:0]] = d;
        do_stop();
    endtask

    initial begin
        logic a, rel;
        logic [7:0] v;
        logic [7:0] pw [4];
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sda_pull == 1'b0, "R5 reset line released", sda_pull, 0);

        // R1/R2: sweep every strap code
        for (int s = 0; s < 8; s++) begin
            do_start();
            put_byte(sel(3'(s), 1'b0), a);
            chk(a == (3'(s) == MY_STRAP), "R1 R2 strap sweep ack", a, (3'(s) == MY_STRAP));
            if (3'(s) != MY_STRAP) begin
                put_byte(8'h00, a);
                chk(a == 1'b0, "R2 silent after mismatch", a, 0);
            end
            do_stop();
        end
        do_start();
        put_byte({4'b1011, MY_STRAP, 1'b0}, a);
        chk(a == 1'b0, "R2 wrong fixed code", a, 0);
        do_stop();

        // seed bytes for later pointer checks
        byte_write(15'h0102, 8'h3C);
        byte_write(15'h0142, 8'h99);

        // R3/R4: page write starting two bytes below the page end, top bit of high byte set
        pw[0] = 8'h11; pw[1] = 8'h80; pw[2] = 8'h01; pw[3] = 8'hC3;
        wr_header(8'h81, 8'h3E);
        for (int k = 0; k < 4; k++) begin
            logic [14:0] ea;
            ea = {9'h004, 6'((6'h3E + k) % 64)};
            put_byte(pw[k], a);
            chk(a, "R4 page data ack", a, 1);
            chk(cap_addr == ea, "R3 R4 write address", cap_addr, ea);
            chk(cap_data == pw[k], "R4 write data", cap_data, pw[k]);
            model[ea[7:0]] = pw[k];
        end
        do_stop();

        // R9: pointer after page write is 0x0102 (page wrap), byte 0x3C
        do_start();
        put_byte(sel(MY_STRAP, 1'b1), a);
        chk(a, "R1 read select ack", a, 1);
        get_byte(1'b1, v, rel);
        chk(v == model[8'h02], "R9 current read after write", v, model[8'h02]);
        chk(rel, "R5 released in host ack slot", rel, 1);
        do_stop();

        // R8/R6: random read from 0x013E for four bytes, crossing into the next page
        wr_header(8'h01, 8'h3E);
        do_start();
        put_byte(sel(MY_STRAP, 1'b1), a);
        chk(a, "R8 repeated start read ack", a, 1);
        for (int k = 0; k < 4; k++) begin
            logic [7:0] ex;
            ex = model[8'(8'h3E + k)];
            get_byte(k == 3, v, rel);
            chk(v == ex, "R8 R6 sequential read", v, ex);
        end
        // R7: further clocks after not-acknowledge draw nothing
        for (int k = 0; k < 9; k++) begin
            chk(sda_pull == 1'b0, "R7 silent after nack", sda_pull, 0);
            host_bit(k[0]);
        end
        do_stop();

        // R9: read pointer after sequential read is 0x0142
        do_start();
        put_byte(sel(MY_STRAP, 1'b1), a);
        get_byte(1'b1, v, rel);
        chk(v == 8'h99, "R9 current read after read", v, 8'h99);
        do_stop();

        // R6/R11: wrap from 0x7FFF to 0x0000
        byte_write(15'h7FFF, 8'h5A);
        byte_write(15'h0000, 8'hA5);
        wr_header(8'h7F, 8'hFF);
        do_start();
        put_byte(sel(MY_STRAP, 1'b1), a);
        get_byte(1'b0, v, rel);
        chk(v == 8'h5A, "R6 R11 read at top address", v, 8'h5A);
        get_byte(1'b1, v, rel);
        chk(v == 8'hA5, "R6 wrap to zero", v, 8'hA5);
        do_stop();

        // R10: start in the middle of an address byte
        do_start();
        put_byte(sel(MY_STRAP, 1'b0), a);
        host_bit(1'b1); host_bit(1'b0); host_bit(1'b1);
        do_start();
        put_byte(sel(MY_STRAP, 1'b0), a);
        chk(a, "R10 select after abort", a, 1);
        put_byte(8'h01, a);
        put_byte(8'h01, a);
        do_start();
        put_byte(sel(MY_STRAP, 1'b1), a);
        host_bit(1'b1); host_bit(1'b1);  // 0xC3 bits 7,6 are 1
        chk(sda_pull == 1'b1, "R5 zero bit pulls line", sda_pull, 1);
        do_start();
        chk(sda_pull == 1'b0, "R10 start releases line", sda_pull, 0);
        wr_header(8'h01, 8'h01);
        do_start();
        put_byte(sel(MY_STRAP, 1'b1), a);
        get_byte(1'b1, v, rel);
        chk(v == 8'hC3, "R10 R8 read after aborts", v, 8'hC3);
        do_stop();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule